// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel characters into asynchronous serial frames. A host writes a character into a visible holding register; as soon as the hidden shift register is idle, the character moves into it. The block then sends a start bit, the data bits least significant first, an optional parity bit and one, one-and-a-half or two stop bits. While one character is being shifted out, the next one can wait in the holding register. Two flags tell the host when the holding register can take a new character and when the whole transmitter has gone quiet.

Bit timing comes from a single-cycle enable pulse, `tick`, that runs at sixteen times the bit rate. The block does not generate this pulse itself. A 7-bit line-control word sets the character length, the parity mode and the stop-bit count, and it carries a break control. The word length, parity and stop settings are sampled when a character moves into the shifter. The break control acts immediately.

The frame engine is a Moore machine with five states:
- `ST_IDLE`: the line is high. Moves to `ST_START` when the holding register is full.
- `ST_START`: the line is low. Moves to `ST_DATA` after one bit time.
- `ST_DATA`: the line carries shifter bit 0. After each bit time the shifter moves right. After the last data bit it moves to `ST_PARITY` if parity is on, or to `ST_STOP` if not.
- `ST_PARITY`: the line carries the captured parity bit. Moves to `ST_STOP` after one bit time.
- `ST_STOP`: the line is high. Moves to `ST_IDLE` after the selected stop length.

Top module: `sertx_top`

## Requirements
- R1: After reset, `txd` is 1, and `hold_empty` and `shift_empty` are both 1.
- R2: A write (`wr_en`=1) makes `hold_empty` 0 at the next edge. A write while the holding register is still full replaces the pending character with no other effect: only the later character is sent.
- R3: At the first edge where the shifter is idle and the holding register is full, the character moves to the shifter. At that same edge, `hold_empty` becomes 1 (unless a write lands in the same cycle), `shift_empty` becomes 0 and `txd` drops to 0 for the start bit.
- R4: A frame is a start bit (0), the data bits LSB first, then parity if enabled, then stop bits (1). Each bit lasts 16 ticks. `line_ctl[1:0]` selects 5, 6, 7 or 8 data bits for the codes 00, 01, 10 and 11. Data bits above the selected length are not sent.
- R5: `line_ctl[3]`=1 adds a parity bit. With `line_ctl[5]`=0, `line_ctl[4]`=1 selects even parity (data ones plus the parity bit give an even count) and `line_ctl[4]`=0 selects odd parity.
- R6: When parity is enabled and `line_ctl[5]`=1, the parity bit is the inverse of `line_ctl[4]`, whatever the data (0x3A gives 7 data bits, parity 0, one stop bit).
- R7: With `line_ctl[2]`=0, the stop time is 16 ticks. With `line_ctl[2]`=1, it is 32 ticks, except with 5 data bits, where it is 24 ticks.
- R8: `shift_empty` returns to 1 at the edge of the last stop tick. While the shifter is idle and no break is set, `txd` is 1.
- R9: `line_ctl[6]`=1 forces `txd` to 0 for as long as it is set. Framing goes on underneath it, and the break does not start a frame.
- R10: The format fields `line_ctl[5:0]` are sampled when a character moves to the shifter. Changing them during a frame does not change that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle enable at 16x the bit rate |
| line_ctl | input | 7 | Line control: [1:0] length, [2] stop, [3] parity on, [4] even, [5] stick, [6] break |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to write |
| txd | output | 1 | Serial output, idle high |
| hold_empty | output | 1 | Holding register can take a character |
| shift_empty | output | 1 | Shifter idle, no frame in progress |

## Verification
The checker tests these on every cycle:
- the forced-low break output;
- the high idle level;
- the flag response to a write;
- the automatic transfer from the holding register into an idle shifter;
- the start bit and the cleared holding flag that follow a transfer.

Only the bench scenarios can show the frame contents and their timing:
- the bit order;
- the selected word length;
- the even, odd and stick parity values;
- the 16, 24 or 32 tick stop lengths;
- that an overwritten pending character is lost;
- that format changes in mid-frame are ignored.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic       par_stick;
        logic       par_even;
        logic       par_en;
        logic       long_stop;
        logic [1:0] wlen;
    } tx_fmt_t;

    function automatic tx_fmt_t fmt_decode(input logic [5:0] ctl);
        tx_fmt_t f;
        f.wlen      = ctl[1:0];
        f.long_stop = ctl[2];
        f.par_en    = ctl[3];
        f.par_even  = ctl[4];
        f.par_stick = ctl[5];
        return f;
    endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              take,
    output logic [CHAR_W-1:0] hold_data,
    output logic              hold_full
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_full <= 1'b0;
        end else if (wr_en) begin
            hold_data <= wr_data;
            hold_full <= 1'b1;
        end else if (take) begin
            hold_full <= 1'b0;
        end
    end

endmodule

// File: rtl/sertx_parity.sv
module sertx_parity
    import sertx_pkg::*;
(
    input  logic [CHAR_W-1:0] data,
    input  tx_fmt_t           fmt,
    output logic              par_bit
);

    logic [CHAR_W-1:0] mask;
    logic [CHAR_W-1:0] kept;

    always_comb begin
        mask = {CHAR_W{1'b1}} >> (2'd3 - fmt.wlen);
        kept = data & mask;
        if (fmt.par_stick)
            par_bit = ~fmt.par_even;
        else if (fmt.par_even)
            par_bit = ^kept;
        else
            par_bit = ~^kept;
    end

endmodule

// File: rtl/sertx_frame_fsm.sv
module sertx_frame_fsm
    import sertx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hold_full,
    input  logic [CHAR_W-1:0] hold_data,
    input  tx_fmt_t           fmt_in,
    input  logic              par_in,
    output logic              take,
    output logic              line,
    output logic              busy
);

    localparam int CNT_W = $clog2(2 * TICKS_PER_BIT);
    localparam logic [CNT_W-1:0] LAST_BIT   = CNT_W'(TICKS_PER_BIT - 1);
    localparam logic [CNT_W-1:0] LAST_HALF  = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_TWO   = CNT_W'(2 * TICKS_PER_BIT - 1);

    tx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [2:0]        bit_q;
    logic [CHAR_W-1:0] sh_q;
    tx_fmt_t           fmt_q;
    logic              par_q;

    logic              bit_end;
    logic              stop_end;
    logic [CNT_W-1:0]  stop_last;
    logic [2:0]        last_idx;

    always_comb begin
        last_idx = 3'd4 + {1'b0, fmt_q.wlen};
        if (!fmt_q.long_stop)
            stop_last = LAST_BIT;
        else if (fmt_q.wlen == 2'b00)
            stop_last = LAST_HALF;
        else
            stop_last = LAST_TWO;
        bit_end  = tick && (cnt_q == LAST_BIT);
        stop_end = tick && (cnt_q == stop_last);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (hold_full) begin
                    state_d = ST_START;
                    take    = 1'b1;
                end
            end
            ST_START: if (bit_end) state_d = ST_DATA;
            ST_DATA: begin
                if (bit_end && bit_q == last_idx)
                    state_d = fmt_q.par_en ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: if (bit_end) state_d = ST_STOP;
            ST_STOP:   if (stop_end) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath: tick counter, bit index, shifter, captured format
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bit_q <= '0;
            sh_q  <= '0;
            fmt_q <= '0;
            par_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE || state_d != state_q)
                cnt_q <= '0;
            else if (bit_end && state_q == ST_DATA)
                cnt_q <= '0;
            else if (tick)
                cnt_q <= cnt_q + 1'b1;

            if (take) begin
                sh_q  <= hold_data;
                fmt_q <= fmt_in;
                par_q <= par_in;
                bit_q <= '0;
            end else if (state_q == ST_DATA && bit_end) begin
                sh_q  <= sh_q >> 1;
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:   line = 1'b1;
            ST_START:  line = 1'b0;
            ST_DATA:   line = sh_q[0];
            ST_PARITY: line = par_q;
            ST_STOP:   line = 1'b1;
            default:   line = 1'b1;
        endcase
        busy = (state_q != ST_IDLE);
    end

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [6:0] line_ctl,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       txd,
    output logic       hold_empty,
    output logic       shift_empty
);

    logic              hold_full;
    logic [CHAR_W-1:0] hold_data;
    logic              take;
    logic              line;
    logic              busy;
    logic              par_bit;
    tx_fmt_t           fmt_live;

    assign fmt_live = fmt_decode(line_ctl[5:0]);

    sertx_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .take      (take),
        .hold_data (hold_data),
        .hold_full (hold_full)
    );

    sertx_parity u_par (
        .data    (hold_data),
        .fmt     (fmt_live),
        .par_bit (par_bit)
    );

    sertx_frame_fsm #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .fmt_in    (fmt_live),
        .par_in    (par_bit),
        .take      (take),
        .line      (line),
        .busy      (busy)
    );

    assign txd         = line & ~line_ctl[6];
    assign hold_empty  = ~hold_full;
    assign shift_empty = ~busy;

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] line_ctl,
    input logic       wr_en,
    input logic       txd,
    input logic       hold_empty,
    input logic       shift_empty
);

    assert_reset_flags_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (hold_empty && shift_empty));

    assert_write_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !hold_empty);

    assert_auto_transfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_empty && !hold_empty) |=> !shift_empty);

    assert_transfer_frees_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(shift_empty) && !$past(wr_en)) |-> hold_empty);

    assert_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(shift_empty) && !line_ctl[6]) |-> !txd);

    assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_empty && !line_ctl[6]) |-> txd);

    assert_break_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        line_ctl[6] |-> !txd);

endmodule

bind sertx_top sertx_checker u_sertx_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_ctl    (line_ctl),
    .wr_en       (wr_en),
    .txd         (txd),
    .hold_empty  (hold_empty),
    .shift_empty (shift_empty)
);

// File: tb/sertx_top_bench.sv
module sertx_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [6:0] line_ctl = 7'h03;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, hold_empty, shift_empty;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    sertx_top u_sertx_top (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line_ctl(line_ctl),
        .wr_en(wr_en), .wr_data(wr_data), .txd(txd),
        .hold_empty(hold_empty), .shift_empty(shift_empty)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    end

    // {line_ctl, data, expected parity bit, expected ticks to shift_empty}
    localparam logic [24:0] VEC [8] = '{
        {8'h03, 8'h55, 1'b0, 8'd160},
        {8'h1B, 8'h07, 1'b1, 8'd176},
        {8'h0A, 8'h7F, 1'b0, 8'd160},
        {8'h3A, 8'h01, 1'b0, 8'd160},
        {8'h04, 8'hFA, 1'b0, 8'd120},
        {8'h05, 8'h2C, 1'b0, 8'd144},
        {8'h2B, 8'h01, 1'b1, 8'd176},
        {8'h0E, 8'h00, 1'b1, 8'd176}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_char(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Waits for the start bit, samples each bit at its 8th tick, counts ticks
    // until the shifter is idle again.
    task automatic capture(input bit do_mid, input logic [6:0] mid_ctl,
                           output logic [15:0] smp, output int ticks);
        int guard = 0;
        logic tk;
        smp = '0; ticks = 0;
        while (txd !== 1'b0 && guard < 4000) begin
            @(posedge clk); #1; guard++;
        end
        if (do_mid) line_ctl = mid_ctl;
        while (shift_empty !== 1'b1 && guard < 4000) begin
            @(posedge clk); tk = tick; #1; guard++;
            if (tk) begin
                ticks++;
                if (ticks % 16 == 8 && ticks / 16 < 16) smp[ticks / 16] = txd;
            end
        end
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] smp;
        int ticks;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 txd", int'(txd), 1);
        check("R1 hold_empty", int'(hold_empty), 1);
        check("R1 shift_empty", int'(shift_empty), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table walk: R4 data, R5/R6 parity, R7 stop timing
        for (int i = 0; i < 8; i++) begin
            logic [7:0] lc, dd;
            logic       ep;
            int         et, nb;
            {lc, dd, ep, et} = {VEC[i][24:17], VEC[i][16:9], VEC[i][8], 32'(VEC[i][7:0])};
            line_ctl = lc[6:0];
            nb = 5 + int'(lc[1:0]);
            write_char(dd);
            capture(1'b0, 7'h0, smp, ticks);
            check("R4 start", int'(smp[0]), 0);
            for (int b = 0; b < nb; b++) check("R4 data", int'(smp[1 + b]), int'(dd[b]));
            if (lc[3]) check(lc[5] ? "R6 stick parity" : "R5 parity", int'(smp[1 + nb]), int'(ep));
            check("R7 ticks", ticks, et);
            @(negedge clk);
            check("R8 idle", int'(txd), 1);
        end

        // R3 transfer timing
        line_ctl = 7'h03;
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h81;
        @(negedge clk);
        wr_en = 1'b0;
        check("R2 hold_empty after write", int'(hold_empty), 0);
        @(negedge clk);
        check("R3 hold_empty after transfer", int'(hold_empty), 1);
        check("R3 shift_empty after transfer", int'(shift_empty), 0);
        check("R3 start bit", int'(txd), 0);
        capture(1'b0, 7'h0, smp, ticks);
        check("R8 shift_empty end", int'(shift_empty), 1);

        // R2 overwrite of a pending character
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h11;
        @(negedge clk);
        wr_data = 8'hA5;
        @(negedge clk);
        wr_data = 8'h3C;
        @(negedge clk);
        wr_en = 1'b0;
        check("R3 hold full while shifting", int'(hold_empty), 0);
        capture(1'b0, 7'h0, smp, ticks);
        check("R3 first frame", int'(smp[8:1]), 8'h11);
        capture(1'b0, 7'h0, smp, ticks);
        check("R2 overwritten frame", int'(smp[8:1]), 8'h3C);
        check("R2 ticks", ticks, 160);
        @(negedge clk);
        check("R2 no further frame", int'(shift_empty), 1);

        // R10 format captured at transfer
        line_ctl = 7'h03;
        write_char(8'hC3);
        capture(1'b1, 7'h0C, smp, ticks);
        check("R10 ticks", ticks, 160);
        check("R10 data", int'(smp[8:1]), 8'hC3);
        line_ctl = 7'h03;

        // R9 break while idle
        @(negedge clk);
        line_ctl = 7'h43;
        repeat (4) @(negedge clk);
        check("R9 break idle txd", int'(txd), 0);
        check("R9 break starts no frame", int'(shift_empty), 1);
        line_ctl = 7'h03;
        @(negedge clk);
        check("R9 release", int'(txd), 1);

        // R9 break during a frame
        write_char(8'hFF);
        repeat (20) @(negedge clk);
        line_ctl = 7'h43;
        repeat (40) @(negedge clk);
        check("R9 break mid-frame txd", int'(txd), 0);
        check("R9 framing continues", int'(shift_empty), 0);
        line_ctl = 7'h03;
        repeat (400) @(negedge clk);
        check("R9 frame completes", int'(shift_empty), 1);
        check("R8 idle after break", int'(txd), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule